// File: doc/BRIEF.md
# Manchester Transmit Encoder with Selectable Idle

This block turns a non-return-to-zero bit stream into a Manchester-coded line signal for a 10 Mb/s link. It runs on a single 20 MHz reference clock and divides it by two into a free-running transmit bit clock. The sender uses that clock to present a transmit enable and one data bit per cell. Each bit cell spans two reference cycles. The block drives a logical plus/minus pair that stands in for a differential line driver. It also exports the encoded level as a single serial stream for a local loopback path.

A frame always ends on a rising transition of the plus wire. After that, the line settles into one of two idle behaviours chosen by a mode input. Full-step idle holds plus high and minus low. Half-step idle first holds the high level for a short interval, then drops both wires low (zero differential) for a guaranteed quiet window. While loopback is requested, the line pair is held at idle and only the serial stream carries the encoded data.

The controller has four states. ST_IDLE waits for a cell boundary with enable high; that is the transition *start*. ST_SEND encodes cells and takes one of three transitions: *continue* (enable high at a boundary, stay in ST_SEND), *end-full* (enable low in full-step mode, go to ST_IDLE) and *end-half* (enable low in half-step mode, go to ST_HOLD). ST_HOLD keeps plus high until its timer expires; that is the transition *hold-done*, to ST_QUIET. ST_QUIET keeps both wires low for the guard window and then takes *quiet-done* back to ST_IDLE.

Top module: `manchester_tx`

## Requirements
- R1: `tx_clk` runs continuously at half the `clk` rate. It is high in the first reference cycle of every bit cell and low in the second.
- R2: `tx_en` and `tx_data` are sampled at the `clk` edge where `tx_clk` rises. A cell sampled with enable high appears on the line during the two reference cycles that follow that edge.
- R3: During a frame, a data bit of 1 drives `line_p` low in the first half-cell and high in the second. A bit of 0 drives it high then low. `line_n` is the complement of `line_p` in every frame cycle.
- R4: A frame ends at the first cell boundary that samples `tx_en` low. The last transition is always plus rising: with a final bit of 1 it is the mid-cell rise, and with a final bit of 0 it is a rise at the cell boundary.
- R5: With `mode_half` = 0 (full-step), the idle line is `line_p` = 1 and `line_n` = 0, both after reset and after every frame.
- R6: With `mode_half` = 1 (half-step), the line holds `line_p` = 1 and `line_n` = 0 for HOLD_CYC reference cycles counted from the final rising transition. For a final bit of 1, this count includes the second half of the last cell. Both wires then go low.
- R7: In half-step mode, both wires stay low for at least QUIET_CYC reference cycles after the hold. `tx_en` sampled high at any boundary during the hold or the quiet window is ignored and starts no frame. Half-step idle keeps both wires low.
- R8: One cycle after `loopback` is seen high, `line_p` equals the inverse of `mode_half` and `line_n` is 0, whatever the encoder is doing.
- R9: `ser_out` always carries the encoded plus level: the frame waveform, the hold and quiet levels, and the idle level. It is unaffected by `loopback`.
- R10: Reset is synchronous and active high. While it is asserted, `tx_clk` is 1, the encoder is in ST_IDLE, and the line is at the idle level selected by `mode_half`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 20 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable, sampled at the tx_clk rising edge |
| tx_data | input | 1 | NRZ data bit, sampled with tx_en |
| mode_half | input | 1 | Idle mode: 0 full-step, 1 half-step |
| loopback | input | 1 | Hold the line pair at idle |
| tx_clk | output | 1 | Bit clock, reference divided by two |
| line_p | output | 1 | Plus wire of the line pair |
| line_n | output | 1 | Minus wire of the line pair |
| ser_out | output | 1 | Encoded serial stream for loopback |

## Verification
The bench uses the default HOLD_CYC = 4 and QUIET_CYC = 16, which correspond to 200 ns and 800 ns at the reference rate. With these windows short, every frame can be checked in full, through to idle, on every cycle.

It sends every data pattern of one to four bits in each combination of idle mode and loopback. This covers both final-bit values and both tail shapes, as well as loopback forcing in both idle modes.

In half-step frames, the bench holds enable high across the hold and quiet windows. This shows that such requests are ignored, and that enable is honoured again only once ST_IDLE is reached.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_QUIET = 2'd3
    } mtx_state_e;
endpackage

// File: rtl/mtx_phase.sv
module mtx_phase (
    input  logic clk,
    input  logic rst,
    output logic ph,
    output logic tx_clk
);
    // ph = 0 in the first half-cell, 1 in the second
    always_ff @(posedge clk) begin
        if (rst) ph <= 1'b0;
        else     ph <= ~ph;
    end

    assign tx_clk = ~ph;
endmodule

// File: rtl/mtx_timer.sv
module mtx_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/mtx_line.sv
module mtx_line (
    input  logic clk,
    input  logic rst,
    input  logic mode_half,
    input  logic loopback,
    input  logic p_nx,
    input  logic n_nx,
    output logic line_p,
    output logic line_n
);
    always_ff @(posedge clk) begin
        if (rst || loopback) begin
            line_p <= ~mode_half;
            line_n <= 1'b0;
        end else begin
            line_p <= p_nx;
            line_n <= n_nx;
        end
    end

    AST_LOOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(loopback) |-> (line_p == !$past(mode_half)) && !line_n); // R8
endmodule

// File: rtl/manchester_tx.sv
module manchester_tx #(
    parameter int HOLD_CYC  = 4,
    parameter int QUIET_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic tx_data,
    input  logic mode_half,
    input  logic loopback,
    output logic tx_clk,
    output logic line_p,
    output logic line_n,
    output logic ser_out
);
    import mtx_pkg::*;

    localparam int MAXC = (HOLD_CYC > QUIET_CYC) ? HOLD_CYC : QUIET_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LD_HOLD0 = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] LD_HOLD1 = CW'(HOLD_CYC - 2);
    localparam logic [CW-1:0] LD_QUIET = CW'(QUIET_CYC - 1);

    mtx_state_e    state, state_nx;
    logic          ph, zero, ld;
    logic [CW-1:0] ld_val;
    logic          bit_q, bit_nx;
    logic          raw_p, raw_n, p_nx, n_nx;

    mtx_phase u_phase (.clk(clk), .rst(rst), .ph(ph), .tx_clk(tx_clk));

    mtx_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(ld), .load_val(ld_val), .zero(zero)
    );

    always_comb begin
        state_nx = state;
        bit_nx   = bit_q;
        p_nx     = raw_p;
        n_nx     = raw_n;
        ld       = 1'b0;
        ld_val   = '0;
        unique case (state)
            ST_IDLE: begin
                p_nx = ~mode_half;
                n_nx = 1'b0;
                if (ph && tx_en) begin            // start
                    state_nx = ST_SEND;
                    bit_nx   = tx_data;
                    p_nx     = ~tx_data;
                    n_nx     = tx_data;
                end
            end
            ST_SEND: begin
                if (!ph) begin                    // mid-cell: level = bit
                    p_nx = bit_q;
                    n_nx = ~bit_q;
                end else if (tx_en) begin         // continue
                    bit_nx = tx_data;
                    p_nx   = ~tx_data;
                    n_nx   = tx_data;
                end else begin                    // end: final rise
                    p_nx = 1'b1;
                    n_nx = 1'b0;
                    if (mode_half) begin          // end-half
                        state_nx = ST_HOLD;
                        ld       = 1'b1;
                        ld_val   = bit_q ? LD_HOLD1 : LD_HOLD0;
                    end else begin                // end-full
                        state_nx = ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                p_nx = 1'b1;
                n_nx = 1'b0;
                if (zero) begin                   // hold-done
                    state_nx = ST_QUIET;
                    ld       = 1'b1;
                    ld_val   = LD_QUIET;
                    p_nx     = 1'b0;
                end
            end
            ST_QUIET: begin
                p_nx = 1'b0;
                n_nx = 1'b0;
                if (zero) state_nx = ST_IDLE;     // quiet-done
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            bit_q <= 1'b0;
        end else begin
            state <= state_nx;
            bit_q <= bit_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_p <= ~mode_half;
            raw_n <= 1'b0;
        end else begin
            raw_p <= p_nx;
            raw_n <= n_nx;
        end
    end

    mtx_line u_line (
        .clk(clk), .rst(rst), .mode_half(mode_half), .loopback(loopback),
        .p_nx(p_nx), .n_nx(n_nx), .line_p(line_p), .line_n(line_n)
    );

    assign ser_out = raw_p;

    AST_MID_FLIP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEND && ph) |-> (raw_p != $past(raw_p))); // R3
    AST_DIFF_SEND: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEND) |-> (raw_n == !raw_p)); // R3
    AST_END_RISE: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_SEND && state != ST_SEND) |-> (raw_p && !raw_n)); // R4
    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state == ST_QUIET) |-> (!raw_p && !raw_n)); // R7
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD || state == ST_QUIET) |=> (state != ST_SEND)); // R7
    AST_PARAMS: assert property (@(posedge clk) disable iff (rst)
        (HOLD_CYC >= 2) && (QUIET_CYC >= 1)); // R6
endmodule

// File: tb/manchester_tx_tb.sv
module manchester_tx_tb;
    localparam int HOLD  = 4;
    localparam int QUIET = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 1'b0, tx_data = 1'b0, sel = 1'b0, lb = 1'b0;
    logic tx_clk, line_p, line_n, ser_out;
    int   n_cmp = 0, n_bad = 0, cyc = 0;

    always #2 clk = ~clk;

    manchester_tx #(.HOLD_CYC(HOLD), .QUIET_CYC(QUIET)) u_dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .tx_data(tx_data),
        .mode_half(sel), .loopback(lb), .tx_clk(tx_clk),
        .line_p(line_p), .line_n(line_n), .ser_out(ser_out)
    );

    task automatic chk(input logic ep, input logic en_, input logic ck,
                       input bit use_ck, input string tag);
        logic xp, xn;
        xp = lb ? !sel : ep;
        xn = lb ? 1'b0 : en_;
        n_cmp++;
        if (line_p !== xp || line_n !== xn || ser_out !== ep ||
            (use_ck && tx_clk !== ck)) begin
            n_bad++;
            $display("FAIL %s: p/n/ser/clk = %b%b%b%b expected %b%b%b%b",
                     tag, line_p, line_n, ser_out, tx_clk, xp, xn, ep, ck);
        end
    endtask

    task automatic sync();
        @(negedge clk);
        while (tx_clk !== 1'b0) @(negedge clk);
    endtask

    task automatic frame(input int len, input int pat);
        int hl;
        logic last;
        last = 1'b0;
        for (int i = 0; i < len; i++) begin
            tx_en = 1'b1;
            tx_data = pat[i];
            last = pat[i];
            @(negedge clk);
            chk(!last, last, 1'b1, 1, "R1/R2/R3/R8/R9 first half");
            @(negedge clk);
            chk(last, !last, 1'b0, 1, "R1/R3/R8/R9 second half");
        end
        tx_en = 1'b0;
        tx_data = 1'b0;
        if (!sel) begin
            for (int j = 0; j < 6; j++) begin
                @(negedge clk);
                chk(1'b1, 1'b0, 1'b0, 0, "R4/R5 full-step tail");
            end
        end else begin
            hl = last ? HOLD - 1 : HOLD;
            for (int j = 0; j < hl + QUIET + 4; j++) begin
                @(negedge clk);
                if (j == 0) tx_en = 1'b1;
                if (j < hl) chk(1'b1, 1'b0, 1'b0, 0, "R4/R6 half-step hold");
                else        chk(1'b0, 1'b0, 1'b0, 0, "R7 quiet, enable ignored");
                if (j == hl + QUIET - 1) tx_en = 1'b0;
            end
        end
        sync();
    endtask

    initial begin
        sel = 1'b0;
        repeat (3) @(negedge clk);
        chk(1'b1, 1'b0, 1'b1, 1, "R10 reset full-step");
        sel = 1'b1;
        @(negedge clk);
        chk(1'b0, 1'b0, 1'b1, 1, "R10 reset half-step");
        sel = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        sync();
        chk(1'b1, 1'b0, 1'b0, 1, "R5 idle before frame");
        for (int cfg = 0; cfg < 4; cfg++) begin
            sel = cfg[0];
            lb = cfg[1];
            repeat (4) @(negedge clk);
            sync();
            chk(!sel, 1'b0, 1'b0, 1, "R5/R7/R8 idle level");
            for (int len = 1; len <= 4; len++)
                for (int pat = 0; pat < (1 << len); pat++)
                    frame(len, pat);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: cycles %0d expected below %0d", cyc, 100000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule